// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block is the ordering stage for one direction of a bus-to-bus bridge. It latches transactions of five classes in arrival order: posted memory write, delayed read request, delayed write request, delayed read completion and delayed write completion. Each transaction carries a payload index that points into storage held elsewhere. Every cycle the queue picks at most one entry to issue downstream. The choice follows a pass/hold matrix that keeps the producer/consumer model intact, not plain FIFO order.

Downstream readiness is given per class. A class that is blocked downstream does not stall the whole queue. Entries that may legally overtake the blocked ones still issue. Where the matrix only permits a bypass, the queue takes the oldest legal entry. Two configuration inputs relax the bypass duties for systems that do not need them. For a pair that has been relaxed, the queue keeps arrival order, which an optional bypass allows.

Enqueue is a valid/ready stream, with one exception. A beat offered while the queue is full is not held. It is dropped, and a one-cycle overflow flag follows. Issue is a strobe: `out_valid` is raised only when the downstream ready of the issued class is already high, so the entry leaves on that clock edge. The sender sees no back-pressure on the issue side, because readiness is resolved before the strobe.

Top module: `bridge_order_queue`

## Requirements
- R1: While reset is held and after it is released, `empty` is 1 and `full`, `out_valid` and `overflow` are 0.
- R2: Class codes are 0 posted write, 1 read request, 2 write request, 3 read completion and 4 write completion. Bit n of `cls_ready` is the ready of class n. `out_valid` is high only when the ready bit of `out_cls` is high, and the issued entry leaves the queue on that edge.
- R3: Entries of the same class issue strictly in arrival order. In particular, a posted write never overtakes an earlier posted write.
- R4: No entry other than a write completion issues while an older posted write is still queued. A write completion may overtake an older posted write.
- R5: With `relax_pw` low, a posted write whose ready is high issues ahead of older delayed requests and completions whose class is blocked.
- R6: With `relax_cpl` low, a read or write completion whose ready is high issues ahead of older read or write requests whose class is blocked.
- R7: With `relax_pw` high, a posted write waits behind every older delayed request or completion.
- R8: With `relax_cpl` high, a completion waits behind every older read or write request.
- R9: When more than one entry may legally issue, the oldest one issues.
- R10: `in_ready` equals not `full`, and the queue holds DEPTH entries. A beat with `in_valid` high while full is discarded, and `overflow` is 1 for exactly the following cycle.
- R11: A push and an issue in the same cycle are both carried out, and the order of all entries is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| relax_pw | input | 1 | Posted writes keep arrival order behind delayed traffic |
| relax_cpl | input | 1 | Completions keep arrival order behind requests |
| in_valid | input | 1 | Enqueue beat present |
| in_ready | output | 1 | Queue can accept a beat |
| in_cls | input | 3 | Class code of the beat (0..4) |
| in_idx | input | IDX_W | Payload index of the beat |
| cls_ready | input | 5 | Per-class downstream ready |
| out_valid | output | 1 | An entry issues this cycle |
| out_cls | output | 3 | Class of the issued entry |
| out_idx | output | IDX_W | Payload index of the issued entry |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entry held |
| overflow | output | 1 | A beat was dropped in the previous cycle |

## Verification
The bench builds the queue with DEPTH 8 and IDX_W 8. With eight entries the tests can fill the queue completely and show a dropped beat. The same size is still large enough to hold several interleaved classes at once, so an entry can be shown overtaking two or three older ones. Each case first loads the queue with all readies low. It then opens the readies class by class, so that every bypass and every hold in the matrix, including both relaxed modes, produces an issue order that can be predicted.

// File: rtl/ordq_pkg.sv
`timescale 1ns/1ps
package ordq_pkg;
  localparam int NUM_CLS = 5;
  localparam int CLS_W   = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_PW    = 3'd0,
    CLS_RDREQ = 3'd1,
    CLS_WRREQ = 3'd2,
    CLS_RDCPL = 3'd3,
    CLS_WRCPL = 3'd4
  } txn_cls_e;
endpackage

// File: rtl/ordq_pass_rule.sv
`timescale 1ns/1ps
module ordq_pass_rule
  import ordq_pkg::*;
(
  input  txn_cls_e young,
  input  txn_cls_e old,
  input  logic     relax_pw,
  input  logic     relax_cpl,
  output logic     may_pass
);
  logic young_cpl, old_req, old_dly, hold;

  always_comb begin
    young_cpl = (young == CLS_RDCPL) || (young == CLS_WRCPL);
    old_req   = (old == CLS_RDREQ) || (old == CLS_WRREQ);
    old_dly   = (old != CLS_PW);
    hold = 1'b0;
    // same class keeps arrival order
    if (young == old) hold = 1'b1;
    // nothing but a write completion overtakes a posted write
    if (old == CLS_PW && young != CLS_WRCPL) hold = 1'b1;
    // relaxed: posted write stays behind delayed traffic
    if (relax_pw && young == CLS_PW && old_dly) hold = 1'b1;
    // relaxed: completion stays behind requests
    if (relax_cpl && young_cpl && old_req) hold = 1'b1;
    may_pass = !hold;
  end
endmodule

// File: rtl/ordq_store.sv
`timescale 1ns/1ps
module ordq_store
  import ordq_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int IDX_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  txn_cls_e         push_cls,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  input  logic [DEPTH-1:0] pop_sel,
  output logic [DEPTH-1:0] ent_vld,
  output txn_cls_e         ent_cls [DEPTH],
  output logic [IDX_W-1:0] ent_idx [DEPTH],
  output logic [CNT_W-1:0] count
);
  txn_cls_e         cls_q [DEPTH];
  logic [IDX_W-1:0] idx_q [DEPTH];
  txn_cls_e         cls_n [DEPTH];
  logic [IDX_W-1:0] idx_n [DEPTH];
  logic [DEPTH-1:0] shift_m;
  logic [CNT_W-1:0] wr_pos, count_n;

  always_comb begin
    shift_m[0] = pop & pop_sel[0];
    for (int i = 1; i < DEPTH; i++) shift_m[i] = shift_m[i-1] | (pop & pop_sel[i]);
    wr_pos  = count - CNT_W'(pop);
    count_n = count + CNT_W'(push) - CNT_W'(pop);
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = (i < DEPTH - 1) ? i + 1 : i;
      cls_n[i] = cls_q[i];
      idx_n[i] = idx_q[i];
      if (shift_m[i]) begin
        cls_n[i] = cls_q[src];
        idx_n[i] = idx_q[src];
      end
      if (push && CNT_W'(i) == wr_pos) begin
        cls_n[i] = push_cls;
        idx_n[i] = push_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cls_q[i] <= CLS_PW;
        idx_q[i] <= '0;
      end
    end else begin
      count <= count_n;
      for (int i = 0; i < DEPTH; i++) begin
        cls_q[i] <= cls_n[i];
        idx_q[i] <= idx_n[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign ent_vld[g] = CNT_W'(g) < count;
    assign ent_cls[g] = cls_q[g];
    assign ent_idx[g] = idx_q[g];
  end

  // R11: occupancy moves by exactly push minus pop
  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> count == $past(count) + CNT_W'($past(push)) - CNT_W'($past(pop)));
  a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/ordq_pick.sv
`timescale 1ns/1ps
module ordq_pick
  import ordq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH-1:0]   ent_vld,
  input  txn_cls_e           ent_cls [DEPTH],
  input  logic [NUM_CLS-1:0] cls_ready,
  input  logic               relax_pw,
  input  logic               relax_cpl,
  output logic [DEPTH-1:0]   sel_oh,
  output logic               any
);
  logic [DEPTH-1:0] ok_m [DEPTH];
  logic [DEPTH-1:0] elig;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    for (genvar j = 0; j < DEPTH; j++) begin : g_col
      if (j < i) begin : g_older
        logic mp;
        ordq_pass_rule u_rule (
          .young     (ent_cls[i]),
          .old       (ent_cls[j]),
          .relax_pw  (relax_pw),
          .relax_cpl (relax_cpl),
          .may_pass  (mp)
        );
        assign ok_m[i][j] = mp | ~ent_vld[j];
      end else begin : g_young
        assign ok_m[i][j] = 1'b1;
      end
    end
    assign elig[i] = ent_vld[i] & cls_ready[ent_cls[i]] & (&ok_m[i]);
  end

  // oldest eligible entry wins
  assign sel_oh = elig & ~(elig - DEPTH'(1));
  assign any    = |elig;

  a_r9_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh) && (any == (sel_oh != '0)));
  a_r9_pick_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oh & ~ent_vld) == '0);
endmodule

// File: rtl/bridge_order_queue.sv
`timescale 1ns/1ps
module bridge_order_queue
  import ordq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               relax_pw,
  input  logic               relax_cpl,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_cls,
  input  logic [IDX_W-1:0]   in_idx,
  input  logic [4:0]         cls_ready,
  output logic               out_valid,
  output logic [2:0]         out_cls,
  output logic [IDX_W-1:0]   out_idx,
  output logic               full,
  output logic               empty,
  output logic               overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] ent_vld, sel_oh, pw_vec, same_vec;
  txn_cls_e         ent_cls [DEPTH];
  logic [IDX_W-1:0] ent_idx [DEPTH];
  logic [CNT_W-1:0] count;
  logic             push, pop, any;
  txn_cls_e         sel_cls;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign in_ready = !full;
  assign push     = in_valid && in_ready;
  assign pop      = any;

  ordq_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_cls (txn_cls_e'(in_cls)),
    .push_idx (in_idx),
    .pop      (pop),
    .pop_sel  (sel_oh),
    .ent_vld  (ent_vld),
    .ent_cls  (ent_cls),
    .ent_idx  (ent_idx),
    .count    (count)
  );

  ordq_pick #(.DEPTH(DEPTH)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_vld   (ent_vld),
    .ent_cls   (ent_cls),
    .cls_ready (cls_ready),
    .relax_pw  (relax_pw),
    .relax_cpl (relax_cpl),
    .sel_oh    (sel_oh),
    .any       (any)
  );

  always_comb begin
    sel_cls = CLS_PW;
    out_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel_oh[i]) begin
        sel_cls = ent_cls[i];
        out_idx = ent_idx[i];
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      pw_vec[i]   = ent_vld[i] && ent_cls[i] == CLS_PW;
      same_vec[i] = ent_vld[i] && ent_cls[i] == sel_cls;
    end
  end

  assign out_valid = any;
  assign out_cls   = sel_cls;

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= in_valid && full;
  end

  a_r2_ready_class: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cls_ready[out_cls]);
  a_r3_class_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((sel_oh - DEPTH'(1)) & same_vec) == '0);
  a_r4_no_pass_pw: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel_cls != CLS_WRCPL) |-> ((sel_oh - DEPTH'(1)) & pw_vec) == '0);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> overflow);
  a_r10_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_valid) |=> full);
endmodule

// File: tb/bridge_order_queue_test.sv
`timescale 1ns/1ps
module bridge_order_queue_test;
  logic       clk = 0, rst_n = 0, relax_pw = 0, relax_cpl = 0, in_valid = 0;
  logic [2:0] in_cls = 0;
  logic [7:0] in_idx = 0;
  logic [4:0] cls_ready = 0;
  logic       in_ready, out_valid, full, empty, overflow;
  logic [2:0] out_cls;
  logic [7:0] out_idx;

  int    n_vec = 0, n_bad = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bridge_order_queue #(.DEPTH(8), .IDX_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .relax_pw(relax_pw), .relax_cpl(relax_cpl),
    .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls), .in_idx(in_idx),
    .cls_ready(cls_ready), .out_valid(out_valid), .out_cls(out_cls),
    .out_idx(out_idx), .full(full), .empty(empty), .overflow(overflow)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(int c, int idx);
    in_valid = 1; in_cls = 3'(c); in_idx = 8'(idx);
    wait_cyc(1);
  endtask

  task automatic stop_push();
    in_valid = 0;
  endtask

  task automatic expect_item(int c, int idx, string tag);
    exp_q.push_back(c * 256 + idx);
    tag_q.push_back(tag);
  endtask

  task automatic drain(string tag);
    wait_cyc(12);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    check(empty == 1'b1, tag, int'(empty), 1);
    exp_q.delete(); tag_q.delete();
    cls_ready = 0;
    wait_cyc(1);
  endtask

  // monitor: compare every issue against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int got;
      got = int'(out_cls) * 256 + int'(out_idx);
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected issue", got, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, t, got, e);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    wait_cyc(2);
    check(empty == 1 && full == 0 && out_valid == 0 && overflow == 0, "R1 in reset",
          {empty, full, out_valid, overflow}, 8);
    rst_n = 1;
    wait_cyc(1);
    check(empty == 1 && full == 0 && out_valid == 0 && overflow == 0 && in_ready == 1,
          "R1 after reset", {empty, full, out_valid, overflow}, 8);

    // R3 posted writes and same-class completions in order, R9 oldest first
    push(0, 1); push(0, 2); push(0, 3); push(3, 130); push(3, 131); stop_push();
    expect_item(0, 1, "R3 pw order"); expect_item(0, 2, "R3 pw order");
    expect_item(0, 3, "R3 pw order"); expect_item(3, 130, "R3 cpl order");
    expect_item(3, 131, "R3 cpl order");
    cls_ready = 5'b11111;
    drain("R3 drain");

    // R5 posted write bypasses blocked delayed traffic, then R9 oldest first
    push(1, 10); push(3, 11); push(0, 12); stop_push();
    expect_item(0, 12, "R5 pw bypass");
    expect_item(1, 10, "R9 oldest"); expect_item(3, 11, "R9 oldest");
    cls_ready = 5'b00001;
    wait_cyc(4);
    cls_ready = 5'b11111;
    drain("R5 drain");

    // R4 read request held behind posted write, write completion passes
    push(0, 20); push(1, 21); push(4, 22); stop_push();
    expect_item(4, 22, "R4 wrcpl passes pw");
    expect_item(0, 20, "R4 pw first"); expect_item(1, 21, "R4 rdreq after pw");
    cls_ready = 5'b10010;
    wait_cyc(4);
    check(empty == 0, "R4 rdreq held", int'(empty), 0);
    cls_ready = 5'b11111;
    drain("R4 drain");

    // R6 completion bypasses blocked request
    push(2, 30); push(3, 31); stop_push();
    expect_item(3, 31, "R6 cpl bypass"); expect_item(2, 30, "R6 req later");
    cls_ready = 5'b01000;
    wait_cyc(4);
    cls_ready = 5'b11111;
    drain("R6 drain");

    // R7 relaxed posted-write bypass
    relax_pw = 1;
    push(1, 40); push(0, 41); stop_push();
    expect_item(1, 40, "R7 order kept"); expect_item(0, 41, "R7 order kept");
    cls_ready = 5'b00001;
    wait_cyc(4);
    check(empty == 0, "R7 pw held", int'(empty), 0);
    cls_ready = 5'b11111;
    drain("R7 drain");
    relax_pw = 0;

    // R8 relaxed completion bypass
    relax_cpl = 1;
    push(2, 50); push(3, 51); stop_push();
    expect_item(2, 50, "R8 order kept"); expect_item(3, 51, "R8 order kept");
    cls_ready = 5'b01000;
    wait_cyc(4);
    check(empty == 0, "R8 cpl held", int'(empty), 0);
    cls_ready = 5'b11111;
    drain("R8 drain");
    relax_cpl = 0;

    // R10 fill, drop a beat, overflow pulse
    for (int k = 0; k < 8; k++) push(4, 200 + k);
    stop_push();
    check(full == 1, "R10 full", int'(full), 1);
    check(in_ready == 0, "R10 in_ready low", int'(in_ready), 0);
    check(overflow == 0, "R10 no overflow yet", int'(overflow), 0);
    push(4, 250); stop_push();
    check(overflow == 1, "R10 overflow pulse", int'(overflow), 1);
    wait_cyc(1);
    check(overflow == 0, "R10 overflow clears", int'(overflow), 0);
    for (int k = 0; k < 8; k++) expect_item(4, 200 + k, "R10 dropped beat absent");
    cls_ready = 5'b11111;
    drain("R10 drain");

    // R11 push and issue in the same cycle
    cls_ready = 5'b11111;
    for (int k = 0; k < 4; k++) expect_item(0, 100 + k, "R11 stream order");
    for (int k = 0; k < 4; k++) push(0, 100 + k);
    stop_push();
    drain("R11 drain");

    finish_run();
  end
endmodule